// File: doc/BRIEF.md
# Cache Line Coherence State Tracker

This block holds the coherence state of a few cache lines inside a requesting node of a coherent interconnect. Besides the familiar Invalid, Unique Clean, Unique Dirty, Shared Clean and Shared Dirty states, it has two more:

- **Unique Clean Empty** means the node owns the line exclusively but holds none of its data.
- **Unique Dirty Partial** means the node owns the line and a per-byte mask marks the bytes that differ from memory.

A line reaches Unique Clean Empty in two ways. The first is an ownership request that completes after the line was already gone. The second is a snoop that removes the line while that request was still in flight. The completion carries no data, so the node ends up owning a line it does not hold.

The surrounding cache controller drives the block with one-cycle request pulses, each naming a line:

- a fill that installs a shared copy;
- an invalidating snoop;
- the issue and the completion of an ownership request;
- a byte-enabled store;
- an eviction.

The block presents the state, the dirty mask and the pending flag of every line. One cycle after the request, it pulses a reject for a store that lacks ownership, a snoop data-return carrying the dirty mask, or a writeback command. The writeback command is marked full or partial. When several requests hit the same line in one cycle, they take effect in the fixed order fill, snoop, completion, store, eviction.

Top module: `coh_line_tracker`

## Requirements
- R1: After reset every line is Invalid (code 0), with a zero dirty mask, no pending request, and all event outputs low.
- R2: An ownership issue sets the line's pending flag. An issue to a line that is already pending is ignored, and so is an issue in the same cycle as that line's completion. A completion clears the pending flag. A completion to a line with nothing pending changes nothing.
- R3: State codes are I=0, UC=1, UD=2, SC=3, SD=4, UCE=5, UDP=6. An applied completion changes the state as follows:
  - SC becomes UC.
  - SD becomes UD.
  - I becomes UCE. This covers a line that was snooped away while its request was pending.
  - A unique state is left as it is.
- R4: A fill installs SC with mask 0 when its dirty flag is 0, and SD with a full mask when the flag is 1. A store to UC or UCE whose byte enables are neither zero nor all ones moves the line to UDP. After that store, the mask holds exactly the written bytes (bit i is byte i).
- R5: In UDP a store ORs its byte enables into the mask. A store that completes the mask, or any full-line store to a unique line, moves the line to UD with an all-ones mask. A store to UD keeps UD.
- R6: A store to an I, SC or SD line is rejected. The reject output pulses for one cycle, and the line's state and mask stay unchanged.
- R7: A snoop to a UD, SD or UDP line pulses the snoop-data output for one cycle and presents the dirty mask, which is all ones for UD and SD. A snoop to any line leaves it I with a zero mask. The pending flag is not affected.
- R8: Evicting a UDP line issues a partial writeback that carries the dirty mask. Evicting UD or SD issues a full writeback with an all-ones mask. Evicting any other line issues no writeback. The line becomes I in every case.
- R9: When several requests hit one line in the same cycle, they take effect in the order fill, snoop, completion, store, eviction. Each later step sees the result of the earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Install a shared copy |
| fill_line | input | LW | Line index for the fill |
| fill_dirty | input | 1 | 1: install SD, 0: install SC |
| snp_valid | input | 1 | Invalidating snoop |
| snp_line | input | LW | Line index for the snoop |
| req_valid | input | 1 | Ownership request issued |
| req_line | input | LW | Line index for the issue |
| cmp_valid | input | 1 | Ownership request completed |
| cmp_line | input | LW | Line index for the completion |
| st_valid | input | 1 | Local store |
| st_line | input | LW | Line index for the store |
| st_be | input | LB | Store byte enables |
| ev_valid | input | 1 | Eviction |
| ev_line | input | LW | Line index for the eviction |
| line_state_o | output | 3*NL | State code of each line, line i at bits [3i+2:3i] |
| dirty_mask_o | output | LB*NL | Dirty mask of each line |
| pending_o | output | NL | Ownership-pending flag of each line |
| st_reject_o | output | 1 | Store rejected, request ownership |
| snp_data_o | output | 1 | Snoop returns dirty data |
| snp_mask_o | output | LB | Dirty mask returned with the snoop |
| snp_line_o | output | LW | Line of the snoop return |
| wb_valid_o | output | 1 | Writeback command |
| wb_partial_o | output | 1 | 1: partial writeback, 0: full writeback |
| wb_mask_o | output | LB | Bytes to write back |
| wb_line_o | output | LW | Line of the writeback |

## Verification
The collision that matters most is a snoop and the completion of an ownership request hitting the same line in the same cycle. The snoop must act first, so the completion finds the line Invalid and leaves it Unique Clean Empty with no data returned for a clean line. A directed case provokes this after issuing a request on a Shared Clean line and expects state code 5. The random phase also lets stores, snoops and evictions land on the same line together. Each cycle is judged against a bench model that applies the five steps in the required order.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [2:0] {
    CS_I   = 3'd0,
    CS_UC  = 3'd1,
    CS_UD  = 3'd2,
    CS_SC  = 3'd3,
    CS_SD  = 3'd4,
    CS_UCE = 3'd5,
    CS_UDP = 3'd6
  } coh_state_e;

  function automatic logic is_unique(input coh_state_e s);
    return (s == CS_UC) || (s == CS_UD) || (s == CS_UCE) || (s == CS_UDP);
  endfunction

  function automatic logic holds_dirty(input coh_state_e s);
    return (s == CS_UD) || (s == CS_SD) || (s == CS_UDP);
  endfunction

  function automatic coh_state_e promote(input coh_state_e s);
    case (s)
      CS_I:    return CS_UCE;
      CS_SC:   return CS_UC;
      CS_SD:   return CS_UD;
      default: return s;
    endcase
  endfunction
endpackage

// File: rtl/coh_line_slot.sv
module coh_line_slot
  import coh_pkg::*;
#(
  parameter int LB = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fill_hit,
  input  logic          fill_dirty,
  input  logic          snp_hit,
  input  logic          req_hit,
  input  logic          cmp_hit,
  input  logic          st_hit,
  input  logic [LB-1:0] st_be,
  input  logic          ev_hit,
  output coh_state_e    state_o,
  output logic [LB-1:0] mask_o,
  output logic          pend_o,
  output logic          snp_ev_o,
  output logic [LB-1:0] snp_mask_ev_o,
  output logic          wb_ev_o,
  output logic          wb_part_ev_o,
  output logic [LB-1:0] wb_mask_ev_o,
  output logic          rej_ev_o
);
  localparam logic [LB-1:0] FULL = {LB{1'b1}};

  typedef struct packed {
    coh_state_e    st;
    logic [LB-1:0] mk;
  } line_t;

  function automatic line_t apply_store(input line_t cur, input logic [LB-1:0] be);
    line_t r;
    logic [LB-1:0] nm;
    nm = cur.mk | be;
    r = cur;
    if (cur.st == CS_UD) r = '{CS_UD, FULL};
    else if (nm == FULL) r = '{CS_UD, FULL};
    else if (nm != '0)   r = '{CS_UDP, nm};
    return r;
  endfunction

  coh_state_e    state_q;
  logic [LB-1:0] mask_q;
  logic          pend_q;

  line_t s_fill, s_snp, s_cmp, s_st, s_ev;
  logic  cmp_apply;

  always_comb begin
    s_fill = '{state_q, mask_q};
    if (fill_hit) s_fill = fill_dirty ? '{CS_SD, FULL} : '{CS_SC, '0};

    snp_ev_o      = 1'b0;
    snp_mask_ev_o = '0;
    s_snp         = s_fill;
    if (snp_hit) begin
      snp_ev_o      = holds_dirty(s_fill.st);
      snp_mask_ev_o = holds_dirty(s_fill.st) ? s_fill.mk : '0;
      s_snp         = '{CS_I, '0};
    end

    cmp_apply = cmp_hit && pend_q;
    s_cmp     = s_snp;
    if (cmp_apply) s_cmp.st = promote(s_snp.st);

    rej_ev_o = st_hit && !is_unique(s_cmp.st);
    s_st     = s_cmp;
    if (st_hit && is_unique(s_cmp.st)) s_st = apply_store(s_cmp, st_be);

    wb_ev_o      = ev_hit && holds_dirty(s_st.st);
    wb_part_ev_o = wb_ev_o && (s_st.st == CS_UDP);
    wb_mask_ev_o = wb_ev_o ? s_st.mk : '0;
    s_ev         = s_st;
    if (ev_hit) s_ev = '{CS_I, '0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CS_I;
      mask_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= s_ev.st;
      mask_q  <= s_ev.mk;
      pend_q  <= pend_q ? !cmp_hit : req_hit;
    end
  end

  assign state_o = state_q;
  assign mask_o  = mask_q;
  assign pend_o  = pend_q;

  assert_udp_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CS_UDP) |-> (mask_q != '0 && mask_q != FULL));
  assert_clean_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q inside {CS_I, CS_UC, CS_UCE, CS_SC}) |-> (mask_q == '0));
  assert_snoop_inval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && !(cmp_hit && pend_q)) |=> (state_q == CS_I && mask_q == '0));
  assert_pend_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && pend_q) |=> !pend_q);
  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_hit && !fill_hit && !snp_hit && !cmp_hit && !ev_hit &&
     (state_q inside {CS_I, CS_SC, CS_SD})) |=> ($stable(state_q) && $stable(mask_q)));
endmodule

// File: rtl/coh_event_collect.sv
module coh_event_collect #(
  parameter int NL = 4,
  parameter int LB = 8,
  parameter int LW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NL-1:0]    snp_ev,
  input  logic [NL*LB-1:0] snp_mask_ev,
  input  logic [LW-1:0]    snp_line,
  input  logic [NL-1:0]    wb_ev,
  input  logic [NL-1:0]    wb_part_ev,
  input  logic [NL*LB-1:0] wb_mask_ev,
  input  logic [LW-1:0]    ev_line,
  input  logic [NL-1:0]    rej_ev,
  output logic             st_reject_o,
  output logic             snp_data_o,
  output logic [LB-1:0]    snp_mask_o,
  output logic [LW-1:0]    snp_line_o,
  output logic             wb_valid_o,
  output logic             wb_partial_o,
  output logic [LB-1:0]    wb_mask_o,
  output logic [LW-1:0]    wb_line_o
);
  localparam logic [LB-1:0] FULL = {LB{1'b1}};

  logic [LB-1:0] snp_m, wb_m;

  always_comb begin
    snp_m = '0;
    wb_m  = '0;
    for (int i = 0; i < NL; i++) begin
      snp_m = snp_m | snp_mask_ev[i*LB +: LB];
      wb_m  = wb_m  | wb_mask_ev[i*LB +: LB];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_reject_o  <= 1'b0;
      snp_data_o   <= 1'b0;
      snp_mask_o   <= '0;
      snp_line_o   <= '0;
      wb_valid_o   <= 1'b0;
      wb_partial_o <= 1'b0;
      wb_mask_o    <= '0;
      wb_line_o    <= '0;
    end else begin
      st_reject_o  <= |rej_ev;
      snp_data_o   <= |snp_ev;
      snp_mask_o   <= snp_m;
      snp_line_o   <= snp_line;
      wb_valid_o   <= |wb_ev;
      wb_partial_o <= |wb_part_ev;
      wb_mask_o    <= wb_m;
      wb_line_o    <= ev_line;
    end
  end

  assert_one_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wb_ev));
  assert_full_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && !wb_partial_o) |-> (wb_mask_o == FULL));
  assert_partial_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && wb_partial_o) |-> (wb_mask_o != FULL && wb_mask_o != '0));
  assert_snp_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_data_o |-> (snp_mask_o != '0));
endmodule

// File: rtl/coh_line_tracker.sv
module coh_line_tracker
  import coh_pkg::*;
#(
  parameter int NL = 4,
  parameter int LB = 8,
  localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_valid,
  input  logic [LW-1:0]    fill_line,
  input  logic             fill_dirty,
  input  logic             snp_valid,
  input  logic [LW-1:0]    snp_line,
  input  logic             req_valid,
  input  logic [LW-1:0]    req_line,
  input  logic             cmp_valid,
  input  logic [LW-1:0]    cmp_line,
  input  logic             st_valid,
  input  logic [LW-1:0]    st_line,
  input  logic [LB-1:0]    st_be,
  input  logic             ev_valid,
  input  logic [LW-1:0]    ev_line,
  output logic [3*NL-1:0]  line_state_o,
  output logic [LB*NL-1:0] dirty_mask_o,
  output logic [NL-1:0]    pending_o,
  output logic             st_reject_o,
  output logic             snp_data_o,
  output logic [LB-1:0]    snp_mask_o,
  output logic [LW-1:0]    snp_line_o,
  output logic             wb_valid_o,
  output logic             wb_partial_o,
  output logic [LB-1:0]    wb_mask_o,
  output logic [LW-1:0]    wb_line_o
);
  logic [NL-1:0]    snp_ev, wb_ev, wb_part_ev, rej_ev;
  logic [NL*LB-1:0] snp_mask_ev, wb_mask_ev;

  for (genvar g = 0; g < NL; g++) begin : g_line
    coh_state_e st;
    coh_line_slot #(.LB(LB)) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .fill_hit     (fill_valid && fill_line == LW'(g)),
      .fill_dirty   (fill_dirty),
      .snp_hit      (snp_valid && snp_line == LW'(g)),
      .req_hit      (req_valid && req_line == LW'(g)),
      .cmp_hit      (cmp_valid && cmp_line == LW'(g)),
      .st_hit       (st_valid && st_line == LW'(g)),
      .st_be        (st_be),
      .ev_hit       (ev_valid && ev_line == LW'(g)),
      .state_o      (st),
      .mask_o       (dirty_mask_o[g*LB +: LB]),
      .pend_o       (pending_o[g]),
      .snp_ev_o     (snp_ev[g]),
      .snp_mask_ev_o(snp_mask_ev[g*LB +: LB]),
      .wb_ev_o      (wb_ev[g]),
      .wb_part_ev_o (wb_part_ev[g]),
      .wb_mask_ev_o (wb_mask_ev[g*LB +: LB]),
      .rej_ev_o     (rej_ev[g])
    );
    assign line_state_o[g*3 +: 3] = st;
  end

  coh_event_collect #(.NL(NL), .LB(LB), .LW(LW)) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_ev      (snp_ev),
    .snp_mask_ev (snp_mask_ev),
    .snp_line    (snp_line),
    .wb_ev       (wb_ev),
    .wb_part_ev  (wb_part_ev),
    .wb_mask_ev  (wb_mask_ev),
    .ev_line     (ev_line),
    .rej_ev      (rej_ev),
    .st_reject_o (st_reject_o),
    .snp_data_o  (snp_data_o),
    .snp_mask_o  (snp_mask_o),
    .snp_line_o  (snp_line_o),
    .wb_valid_o  (wb_valid_o),
    .wb_partial_o(wb_partial_o),
    .wb_mask_o   (wb_mask_o),
    .wb_line_o   (wb_line_o)
  );
endmodule

// File: tb/coh_line_tracker_tb.sv
module coh_line_tracker_tb;
  localparam int NL = 4;
  localparam int LB = 8;
  localparam int LW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic fill_valid = 0, fill_dirty = 0, snp_valid = 0, req_valid = 0;
  logic cmp_valid = 0, st_valid = 0, ev_valid = 0;
  logic [LW-1:0] fill_line = 0, snp_line = 0, req_line = 0, cmp_line = 0;
  logic [LW-1:0] st_line = 0, ev_line = 0;
  logic [LB-1:0] st_be = 0;

  logic [3*NL-1:0]  line_state_o;
  logic [LB*NL-1:0] dirty_mask_o;
  logic [NL-1:0]    pending_o;
  logic st_reject_o, snp_data_o, wb_valid_o, wb_partial_o;
  logic [LB-1:0] snp_mask_o, wb_mask_o;
  logic [LW-1:0] snp_line_o, wb_line_o;

  coh_line_tracker #(.NL(NL), .LB(LB)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;

  int m_st[NL];
  logic [LB-1:0] m_mk[NL];
  logic m_pd[NL];
  logic e_rej, e_snp, e_wb, e_part;
  logic [LB-1:0] e_smask, e_wmask;
  logic [LW-1:0] e_sline, e_wline;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit dirty_st(int s);
    return s == 2 || s == 4 || s == 6;
  endfunction

  function automatic bit uniq_st(int s);
    return s == 1 || s == 2 || s == 5 || s == 6;
  endfunction

  task automatic model_step();
    e_rej = 0; e_snp = 0; e_wb = 0; e_part = 0;
    e_smask = 0; e_wmask = 0;
    e_sline = snp_line; e_wline = ev_line;
    for (int i = 0; i < NL; i++) begin
      int s;
      logic [LB-1:0] m;
      logic pd;
      s = m_st[i]; m = m_mk[i]; pd = m_pd[i];
      if (fill_valid && fill_line == i) begin
        s = fill_dirty ? 4 : 3;
        m = fill_dirty ? '1 : '0;
      end
      if (snp_valid && snp_line == i) begin
        if (dirty_st(s)) begin e_snp = 1; e_smask = m; end
        s = 0; m = 0;
      end
      if (cmp_valid && cmp_line == i && pd) begin
        if (s == 0) s = 5;
        else if (s == 3) s = 1;
        else if (s == 4) s = 2;
      end
      if (st_valid && st_line == i) begin
        if (!uniq_st(s)) e_rej = 1;
        else if (s == 2 || (m | st_be) == '1) begin s = 2; m = '1; end
        else if ((m | st_be) != 0) begin s = 6; m = m | st_be; end
      end
      if (ev_valid && ev_line == i) begin
        if (dirty_st(s)) begin e_wb = 1; e_part = (s == 6); e_wmask = m; end
        s = 0; m = 0;
      end
      if (pd) pd = !(cmp_valid && cmp_line == i);
      else pd = req_valid && req_line == i;
      m_st[i] = s; m_mk[i] = m; m_pd[i] = pd;
    end
  endtask

  task automatic idle();
    fill_valid = 0; snp_valid = 0; req_valid = 0; cmp_valid = 0;
    st_valid = 0; ev_valid = 0;
  endtask

  task automatic compare_all(string tag);
    for (int i = 0; i < NL; i++) begin
      chk({tag, " state"}, 64'(line_state_o[i*3 +: 3]), 64'(m_st[i]));
      chk({tag, " mask"}, 64'(dirty_mask_o[i*LB +: LB]), 64'(m_mk[i]));
      chk({tag, " pend"}, 64'(pending_o[i]), 64'(m_pd[i]));
    end
    chk({tag, " reject"}, 64'(st_reject_o), 64'(e_rej));
    chk({tag, " snp"}, {snp_data_o, e_snp ? {snp_mask_o, 6'(snp_line_o)} : 14'd0},
        {e_snp, e_snp ? {e_smask, 6'(e_sline)} : 14'd0});
    chk({tag, " wb"}, {wb_valid_o, e_wb ? {wb_partial_o, wb_mask_o, 6'(wb_line_o)} : 15'd0},
        {e_wb, e_wb ? {e_part, e_wmask, 6'(e_wline)} : 15'd0});
  endtask

  task automatic tick(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    idle();
    compare_all(tag);
  endtask

  int cyc = 0;
  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R1 actual=%0d expected<100000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_mk[i] = 0; m_pd[i] = 0; end
    e_rej = 0; e_snp = 0; e_wb = 0; e_part = 0; e_smask = 0; e_wmask = 0;
    e_sline = 0; e_wline = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R1 reset");

    // R3: SC line completes to UC
    fill_valid = 1; fill_line = 0; fill_dirty = 0; tick("R4 fill SC");
    req_valid = 1; req_line = 0; tick("R2 issue");
    chk("R2 pending set", 64'(pending_o[0]), 1);
    req_valid = 1; req_line = 0; tick("R2 reissue ignored");
    cmp_valid = 1; cmp_line = 0; tick("R3 SC->UC");
    chk("R3 SC->UC", 64'(line_state_o[2:0]), 1);
    chk("R2 pending cleared", 64'(pending_o[0]), 0);
    cmp_valid = 1; cmp_line = 0; tick("R2 stray completion");
    chk("R2 stray completion", 64'(line_state_o[2:0]), 1);
    // R4: partial store on UC
    st_valid = 1; st_line = 0; st_be = 8'h0F; tick("R4 UC store");
    chk("R4 UDP mask", 64'(dirty_mask_o[7:0]), 64'h0F);
    // R5: completing mask
    st_valid = 1; st_line = 0; st_be = 8'hF0; tick("R5 fill mask");
    chk("R5 UD", 64'(line_state_o[2:0]), 2);
    // R8 full writeback
    ev_valid = 1; ev_line = 0; tick("R8 evict UD");
    chk("R8 full wb", {wb_valid_o, wb_partial_o, wb_mask_o}, {2'b10, 8'hFF});
    // R6 store to I
    st_valid = 1; st_line = 3; st_be = 8'h01; tick("R6 reject");
    chk("R6 reject pulse", 64'(st_reject_o), 1);
    // R9 snoop and completion same cycle -> UCE
    fill_valid = 1; fill_line = 2; fill_dirty = 0; tick("R9 fill");
    req_valid = 1; req_line = 2; tick("R9 issue");
    snp_valid = 1; snp_line = 2; cmp_valid = 1; cmp_line = 2; tick("R9 snoop+cmp");
    chk("R9 UCE", 64'(line_state_o[8:6]), 5);
    chk("R9 no data", 64'(snp_data_o), 0);
    // R4 UCE partial store, R7 snoop returns mask
    st_valid = 1; st_line = 2; st_be = 8'h24; tick("R4 UCE store");
    chk("R4 UCE->UDP", 64'(line_state_o[8:6]), 6);
    snp_valid = 1; snp_line = 2; tick("R7 snoop UDP");
    chk("R7 snoop mask", {snp_data_o, snp_mask_o}, {1'b1, 8'h24});
    // R3 SD -> UD, R8 partial evict
    fill_valid = 1; fill_line = 1; fill_dirty = 1; tick("R4 fill SD");
    req_valid = 1; req_line = 1; tick("R3 issue");
    cmp_valid = 1; cmp_line = 1; tick("R3 SD->UD");
    chk("R3 SD->UD", 64'(line_state_o[5:3]), 2);
    req_valid = 1; req_line = 3; tick("R3 issue I");
    cmp_valid = 1; cmp_line = 3; tick("R3 I->UCE");
    st_valid = 1; st_line = 3; st_be = 8'h80; tick("R4 store");
    ev_valid = 1; ev_line = 3; tick("R8 evict UDP");
    chk("R8 partial wb", {wb_valid_o, wb_partial_o, wb_mask_o}, {2'b11, 8'h80});

    // random phase, all requirements against the model (R9 ordering)
    for (int k = 0; k < 4000; k++) begin
      fill_valid = ($urandom_range(0, 9) < 2); fill_line = LW'($urandom);
      fill_dirty = LW'($urandom) == 0;
      snp_valid = ($urandom_range(0, 9) < 2); snp_line = LW'($urandom);
      req_valid = ($urandom_range(0, 9) < 4); req_line = LW'($urandom);
      cmp_valid = ($urandom_range(0, 9) < 4); cmp_line = LW'($urandom);
      st_valid = ($urandom_range(0, 9) < 5); st_line = LW'($urandom);
      case ($urandom_range(0, 3))
        0: st_be = 8'hFF;
        1: st_be = 8'h01 << $urandom_range(0, 7);
        default: st_be = LB'($urandom);
      endcase
      ev_valid = ($urandom_range(0, 9) < 1); ev_line = LW'($urandom);
      tick("R9 random");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule